// File: doc/BRIEF.md
# Condition-field mask/mode logic unit

This unit performs the bit-test step behind four closely related operations on 4-bit condition fields. Every operation builds four terms. Each term is true when its mask bit is set and the source bit equals the matching mode bit. The four terms are then reduced or merged, depending on the operation selected:

- A field can be reduced to one bit that lands in an integer result.
- The least significant bit of an integer can be spread across a field.
- A field can produce a new field.
- A field can be reduced to one bit aimed at a selected condition bit.

A single M flag selects OR versus AND reduction. For the field results, the same flag selects read-modify-write versus overwrite.

The unit sits between a register-read stage and the register files. It accepts one operation per clock when `in_valid` is high. One cycle later it presents registered results, together with exactly one write enable that names the destination type. Each result register holds its last written value until its own destination is written again. The register files are not part of this block.

Top module: `cond_mask_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all write enables become 0 and all result outputs become 0.
- R2: For each field bit i (LSB0, i = 0..3), the term n_i is `mask[i]` AND (`mode[i]` == source bit i).
- R3: For op 2'b00 (field to integer) and op 2'b10 (field to single bit), the reduced bit is the OR of n0..n3 when `m_flag`=1, and the AND of n0..n3 when `m_flag`=0.
- R4: For op 2'b00, `int_result[0]` carries the reduced bit and `int_result[63:1]` is zero.
- R5: For op 2'b01 (integer to field), every term compares against the same source bit. That bit is `src_int_lsb`, or 0 when `src_int_zero` is 1.
- R6: For op 2'b01 and op 2'b11 (field to field) with `m_flag`=1, the result is n, and field bits whose mask bit is 0 keep their value from `old_field`.
- R7: For op 2'b01 and op 2'b11 with `m_flag`=0, field bits whose mask bit is 0 are written as 0, and `old_field` has no effect.
- R8: For op 2'b10, `bit_fld_idx` equals `bit_sel[4:2]`, `bit_idx` equals `bit_sel[1:0]`, and `bit_val` is the reduced bit.
- R9: One cycle after a cycle with `in_valid`=1, exactly one write enable is 1: `int_we` for 2'b00, `fld_we` for 2'b01 and 2'b11, and `bit_we` for 2'b10. After a cycle with `in_valid`=0, all write enables are 0.
- R10: Results appear one clock after the inputs are accepted. Each result output holds its value in every cycle in which its own write enable is 0, including back-to-back operations of different types.
- R11: For op 2'b01 with a zero source and `m_flag`=1, mode 4'b0000 sets the masked bits of `old_field`, and mode 4'b1111 clears them. All other bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op | input | 2 | 00 field→int, 01 int→field, 10 field→bit, 11 field→field |
| mask | input | 4 | Bit-select mask (LSB0) |
| mode | input | 4 | Per-bit compare pattern (LSB0) |
| m_flag | input | 1 | 1: OR reduce / merge with old; 0: AND reduce / overwrite |
| src_field | input | 4 | Source condition field |
| src_int_lsb | input | 1 | Least significant bit of the integer source |
| src_int_zero | input | 1 | Integer source register index is zero (value 0) |
| old_field | input | 4 | Current value of the destination field |
| bit_sel | input | 5 | Single-bit destination: [4:2] field, [1:0] bit |
| int_we | output | 1 | Integer result write enable |
| int_result | output | 64 | Integer result |
| fld_we | output | 1 | Field result write enable |
| fld_result | output | 4 | Field result |
| bit_we | output | 1 | Single-bit result write enable |
| bit_fld_idx | output | 3 | Field index of the single-bit destination |
| bit_idx | output | 2 | Bit index within that field |
| bit_val | output | 1 | Single-bit result value |

## Verification
Two things can land on the same clock edge. A new operation is captured while the registered result of the previous, differently typed operation appears. The bench provokes this by issuing operations on consecutive cycles with changing op codes, both in a directed run and in a long random stream. Its behavioural model predicts every output on every clock. A leaked write enable, a result register loaded by the wrong operation, or a field merged with the wrong cycle's old value therefore shows up as a mismatch at that edge.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  typedef enum logic [1:0] {
    OP_F2I = 2'b00,
    OP_I2F = 2'b01,
    OP_F2B = 2'b10,
    OP_F2F = 2'b11
  } cmu_op_e;
endpackage

// File: rtl/cmu_match.sv
module cmu_match #(
  parameter int FW = 4
) (
  input  logic [FW-1:0] src,
  input  logic [FW-1:0] mask,
  input  logic [FW-1:0] mode,
  output logic [FW-1:0] terms
);
  for (genvar i = 0; i < FW; i++) begin : g_term
    assign terms[i] = mask[i] & (mode[i] == src[i]);
  end
endmodule

// File: rtl/cmu_reduce.sv
module cmu_reduce #(
  parameter int FW = 4
) (
  input  logic [FW-1:0] terms,
  input  logic          any_mode,
  output logic          red
);
  always_comb begin
    red = any_mode ? (|terms) : (&terms);
  end
endmodule

// File: rtl/cmu_merge.sv
module cmu_merge #(
  parameter int FW = 4
) (
  input  logic [FW-1:0] terms,
  input  logic [FW-1:0] mask,
  input  logic [FW-1:0] old_val,
  input  logic          keep,
  output logic [FW-1:0] merged
);
  for (genvar i = 0; i < FW; i++) begin : g_bit
    assign merged[i] = terms[i] | (keep & ~mask[i] & old_val[i]);
  end
endmodule

// File: rtl/cond_mask_unit.sv
module cond_mask_unit
  import cmu_pkg::*;
#(
  parameter int INT_W = 64,
  parameter int FW    = 4,
  parameter int SEL_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [1:0]           op,
  input  logic [FW-1:0]        mask,
  input  logic [FW-1:0]        mode,
  input  logic                 m_flag,
  input  logic [FW-1:0]        src_field,
  input  logic                 src_int_lsb,
  input  logic                 src_int_zero,
  input  logic [FW-1:0]        old_field,
  input  logic [SEL_W-1:0]     bit_sel,
  output logic                 int_we,
  output logic [INT_W-1:0]     int_result,
  output logic                 fld_we,
  output logic [FW-1:0]        fld_result,
  output logic                 bit_we,
  output logic [SEL_W-$clog2(FW)-1:0] bit_fld_idx,
  output logic [$clog2(FW)-1:0] bit_idx,
  output logic                 bit_val
);
  localparam int BIT_IDX_W = $clog2(FW);
  localparam int FLD_IDX_W = SEL_W - BIT_IDX_W;

  cmu_op_e       op_e;
  logic          int_src_bit;
  logic [FW-1:0] src_vec;
  logic [FW-1:0] terms;
  logic [FW-1:0] merged;
  logic          red;
  logic          is_fld_op;

  assign op_e        = cmu_op_e'(op);
  assign int_src_bit = src_int_zero ? 1'b0 : src_int_lsb;
  assign src_vec     = (op_e == OP_I2F) ? {FW{int_src_bit}} : src_field;
  assign is_fld_op   = (op_e == OP_I2F) || (op_e == OP_F2F);

  cmu_match #(.FW(FW)) u_match (
    .src   (src_vec),
    .mask  (mask),
    .mode  (mode),
    .terms (terms)
  );

  cmu_reduce #(.FW(FW)) u_reduce (
    .terms    (terms),
    .any_mode (m_flag),
    .red      (red)
  );

  cmu_merge #(.FW(FW)) u_merge (
    .terms   (terms),
    .mask    (mask),
    .old_val (old_field),
    .keep    (m_flag),
    .merged  (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_we      <= 1'b0;
      fld_we      <= 1'b0;
      bit_we      <= 1'b0;
      int_result  <= '0;
      fld_result  <= '0;
      bit_val     <= 1'b0;
      bit_fld_idx <= '0;
      bit_idx     <= '0;
    end else begin
      int_we <= in_valid && (op_e == OP_F2I);
      fld_we <= in_valid && is_fld_op;
      bit_we <= in_valid && (op_e == OP_F2B);
      if (in_valid && (op_e == OP_F2I)) begin
        int_result <= {{(INT_W-1){1'b0}}, red};
      end
      if (in_valid && is_fld_op) begin
        fld_result <= merged;
      end
      if (in_valid && (op_e == OP_F2B)) begin
        bit_val     <= red;
        bit_fld_idx <= bit_sel[SEL_W-1:BIT_IDX_W];
        bit_idx     <= bit_sel[BIT_IDX_W-1:0];
      end
    end
  end

  logic [FLD_IDX_W-1:0] unused_w;
  assign unused_w = bit_fld_idx;

  AST_ONE_WE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> $onehot({int_we, fld_we, bit_we})); // R9
  AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !(int_we || fld_we || bit_we)); // R9
  AST_INT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    int_we |-> (int_result[INT_W-1:1] == '0)); // R4
  AST_OR_NONE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b00 && m_flag && ((mask & ~(mode ^ src_field)) == '0))
      |=> !int_result[0]); // R3
  AST_AND_ALL_ONE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b00 && !m_flag && (&mask) && (mode == src_field))
      |=> int_result[0]); // R3
  AST_KEEP_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[0] && m_flag)
      |=> ((fld_result & ~$past(mask)) == ($past(old_field) & ~$past(mask)))); // R6
  AST_CLEAR_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[0] && !m_flag) |=> ((fld_result & ~$past(mask)) == '0)); // R7
  AST_FLD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fld_we |-> $stable(fld_result)); // R10
endmodule

// File: tb/cond_mask_unit_bench.sv
`timescale 1ns/1ps
module cond_mask_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] op = 2'b00;
  logic [3:0] mask = '0, mode = '0, src_field = '0, old_field = '0;
  logic m_flag = 1'b0, src_int_lsb = 1'b0, src_int_zero = 1'b0;
  logic [4:0] bit_sel = '0;
  logic int_we, fld_we, bit_we, bit_val;
  logic [63:0] int_result;
  logic [3:0] fld_result;
  logic [2:0] bit_fld_idx;
  logic [1:0] bit_idx;

  int checks = 0;
  int fails = 0;
  string chk_tag = "R1";

  logic e_int_we = 0, e_fld_we = 0, e_bit_we = 0, e_bit_val = 0;
  logic [63:0] e_int = '0;
  logic [3:0] e_fld = '0;
  logic [2:0] e_bfi = '0;
  logic [1:0] e_bix = '0;

  always #2.5 clk = ~clk;

  cond_mask_unit u_cond_mask_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .mask(mask), .mode(mode),
    .m_flag(m_flag), .src_field(src_field), .src_int_lsb(src_int_lsb),
    .src_int_zero(src_int_zero), .old_field(old_field), .bit_sel(bit_sel),
    .int_we(int_we), .int_result(int_result), .fld_we(fld_we), .fld_result(fld_result),
    .bit_we(bit_we), .bit_fld_idx(bit_fld_idx), .bit_idx(bit_idx), .bit_val(bit_val)
  );

  task automatic chk(string name, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", chk_tag, name, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("int_we", {63'b0, int_we}, {63'b0, e_int_we});
    chk("fld_we", {63'b0, fld_we}, {63'b0, e_fld_we});
    chk("bit_we", {63'b0, bit_we}, {63'b0, e_bit_we});
    chk("int_result", int_result, e_int);
    chk("fld_result", {60'b0, fld_result}, {60'b0, e_fld});
    chk("bit_val", {63'b0, bit_val}, {63'b0, e_bit_val});
    chk("bit_fld_idx", {61'b0, bit_fld_idx}, {61'b0, e_bfi});
    chk("bit_idx", {62'b0, bit_idx}, {62'b0, e_bix});
  endtask

  // Check the outputs produced by the previous stimulus, then apply a new one
  // and predict what the next clock edge must produce.
  task automatic step(input logic v, input logic [1:0] o, input logic [3:0] mk,
                      input logic [3:0] md, input logic m, input logic [3:0] sf,
                      input logic il, input logic iz, input logic [3:0] old,
                      input logic [4:0] sel, input string tag);
    logic [3:0] n;
    logic sbit, r;
    @(negedge clk);
    compare_all();
    in_valid = v; op = o; mask = mk; mode = md; m_flag = m; src_field = sf;
    src_int_lsb = il; src_int_zero = iz; old_field = old; bit_sel = sel;
    chk_tag = tag;
    for (int i = 0; i < 4; i++) begin
      sbit = (o == 2'b01) ? (iz ? 1'b0 : il) : sf[i];
      n[i] = mk[i] && (md[i] == sbit);
    end
    r = m ? (n != 0) : (n == 4'hF);
    e_int_we = v && (o == 2'b00);
    e_fld_we = v && (o == 2'b01 || o == 2'b11);
    e_bit_we = v && (o == 2'b10);
    if (e_int_we) e_int = {63'b0, r};
    if (e_fld_we) e_fld = m ? (n | (old & ~mk)) : n;
    if (e_bit_we) begin
      e_bit_val = r;
      e_bfi = sel / 4;
      e_bix = sel % 4;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired (hung run)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_tag = "R1";
    compare_all();
    rst = 1'b0;
    // R2: per-bit term
    step(1, 2'b11, 4'hF, 4'hA, 0, 4'hA, 0, 0, 4'h0, 0, "R2");
    step(1, 2'b11, 4'hF, 4'hA, 0, 4'h6, 0, 0, 4'h0, 0, "R2");
    // R3 / R4: field to integer reductions
    step(1, 2'b00, 4'h3, 4'h1, 1, 4'h0, 1, 0, 4'h0, 0, "R3");
    step(1, 2'b00, 4'hF, 4'h5, 0, 4'h5, 0, 0, 4'h0, 0, "R3");
    step(1, 2'b00, 4'hF, 4'h5, 0, 4'h4, 1, 0, 4'h0, 0, "R4");
    step(1, 2'b00, 4'h0, 4'h0, 1, 4'h0, 0, 0, 4'h0, 0, "R3");
    // R5: integer to field, zero-register override
    step(1, 2'b01, 4'hF, 4'hF, 0, 4'h0, 1, 0, 4'h0, 0, "R5");
    step(1, 2'b01, 4'hF, 4'hF, 0, 4'hF, 1, 1, 4'h0, 0, "R5");
    step(1, 2'b01, 4'hF, 4'h9, 0, 4'hF, 0, 0, 4'h0, 0, "R5");
    // R6 / R7: merge versus overwrite
    step(1, 2'b11, 4'h5, 4'h5, 1, 4'h5, 0, 0, 4'hA, 0, "R6");
    step(1, 2'b01, 4'h3, 4'h0, 1, 4'h0, 0, 1, 4'hC, 0, "R6");
    step(1, 2'b01, 4'h3, 4'h0, 0, 4'h0, 0, 1, 4'hF, 0, "R7");
    step(1, 2'b11, 4'h6, 4'h2, 0, 4'h2, 0, 0, 4'hF, 0, "R7");
    // R8: single-bit destination selector
    step(1, 2'b10, 4'hF, 4'h3, 1, 4'h3, 0, 0, 4'h0, 5'b10110, "R8");
    step(1, 2'b10, 4'hF, 4'h3, 0, 4'h2, 0, 0, 4'h0, 5'b01001, "R8");
    step(1, 2'b10, 4'h8, 4'h8, 1, 4'h8, 0, 0, 4'h0, 5'b11111, "R8");
    // R9: idle cycles raise no write enable
    step(0, 2'b00, 4'hF, 4'h0, 1, 4'h0, 0, 0, 4'h0, 0, "R9");
    step(0, 2'b11, 4'hF, 4'hF, 1, 4'hF, 1, 0, 4'h0, 5'b00011, "R9");
    // R11: set and clear idioms with a zero source
    step(1, 2'b01, 4'h6, 4'h0, 1, 4'h0, 1, 1, 4'h9, 0, "R11");
    step(1, 2'b01, 4'h6, 4'hF, 1, 4'h0, 1, 1, 4'hF, 0, "R11");
    // R10: back-to-back mixed operations, results hold between writes
    for (int k = 0; k < 8; k++)
      step(1, k[1:0], 4'hF - k[3:0], k[3:0], k[0], k[3:0] ^ 4'h3, k[1], 0, 4'h5, k[4:0], "R10");
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      step(rv[0] | rv[1], rv[3:2], rv[7:4], rv[11:8], rv[12], rv[16:13], rv[17],
           rv[18] & rv[19], rv[23:20], rv[28:24], "R10");
    end
    step(0, 2'b00, 4'h0, 4'h0, 0, 4'h0, 0, 0, 4'h0, 0, "R9");
    @(negedge clk);
    compare_all();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule